// File: doc/BRIEF.md
# Buffered resource slot tracker

This block keeps the occupancy of a single reservation buffer that sits in front of one processor resource. A dispatch stage reads its two-bit status before it sends work toward the resource. It pulses a reserve strobe when an entry is taken and a release strobe when an entry drains. A separate hold flag can be set and cleared to mark the resource as held.

The integer parameter `BUF_SIZE` picks the operating mode. A value of -1 means the resource has no buffer and is always open. A value of 0 makes it a dispatch hazard: a reserve holds the resource from dispatch until software-visible logic clears the hold after the resource's cycles are consumed. A value of 1 means the resource executes in order. Any larger value gives an ordinary out-of-order queue with that many slots.

Top module: `slotbuf_tracker`

## Requirements
- R1: `status_o` takes only the codes 0 (open), 1 (full) and 2 (held). Code 3 never appears.
- R2: When `BUF_SIZE` is 0 and the hold flag is set, `status_o` is 2.
- R3: In every other case, `status_o` is 0 when `BUF_SIZE` is 0 or less, or when at least one free slot remains. Otherwise it is 1.
- R4: During reset, and in the first cycle after it, the free-slot count equals `BUF_SIZE`, or 0 when `BUF_SIZE` is -1 or 0. After reset the hold flag and the overflow bit are clear.
- R5: A lone reserve strobe lowers the free-slot count by one in the next cycle, but only when the count is nonzero. At zero the count stays at zero.
- R6: A release strobe raises the count only when `BUF_SIZE` is positive. For -1 and 0 the count stays at 0.
- R7: When `BUF_SIZE` is 0, a reserve strobe sets the hold flag. The flag then stays set until `hold_clr_i` is seen.
- R8: `hold_set_i` sets the hold flag and `hold_clr_i` clears it, both in the next cycle. When both arrive together, the set wins.
- R9: `in_order_o` is high exactly when `BUF_SIZE` is 1.
- R10: A lone release while the count already equals `BUF_SIZE` leaves the count unchanged and sets `overflow_o`. `overflow_o` stays set until reset.
- R11: When reserve and release arrive in the same cycle on a buffered resource, the count is left unchanged. This holds even when the buffer is empty or full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reserve_i | input | 1 | One entry taken by dispatch |
| release_i | input | 1 | One entry returned |
| hold_set_i | input | 1 | Set the hold flag |
| hold_clr_i | input | 1 | Clear the hold flag |
| status_o | output | 2 | 0 open, 1 full, 2 held |
| free_slots_o | output | CW | Free slot count; CW = clog2(max(BUF_SIZE,1)+1) |
| reserved_o | output | 1 | Hold flag |
| in_order_o | output | 1 | High when BUF_SIZE is 1 |
| overflow_o | output | 1 | Sticky: a release was refused at full |

## Verification
The assertions take nothing for granted about the strobes beyond their being stable around the rising edge. Reserve at zero slots, release at full, and set together with clear are all legal inputs with defined results. The stimulus therefore does not shield the block. It drives directed runs that empty and overfill the buffer and that collide the strobes at empty, mid-level and full. It then applies a long biased pseudo-random phase. The same stimulus drives four instances at once, one for each mode.

// File: rtl/slotbuf_pkg.sv
`timescale 1ns/1ps
package slotbuf_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_FULL = 2'd1,
    ST_HELD = 2'd2
  } slot_status_e;

  typedef enum logic [1:0] {
    MODE_NOBUF   = 2'd0,
    MODE_HAZARD  = 2'd1,
    MODE_INORDER = 2'd2,
    MODE_QUEUE   = 2'd3
  } slot_mode_e;

  function automatic slot_mode_e mode_of(input int size);
    if (size < 0)       return MODE_NOBUF;
    else if (size == 0) return MODE_HAZARD;
    else if (size == 1) return MODE_INORDER;
    else                return MODE_QUEUE;
  endfunction

  // Priority: a held hazard first, then open when unbuffered or a slot is free.
  function automatic slot_status_e encode_status(input slot_mode_e mode,
                                                 input logic held,
                                                 input logic has_free);
    if (mode == MODE_HAZARD && held)                           return ST_HELD;
    if (mode == MODE_NOBUF || mode == MODE_HAZARD || has_free) return ST_OPEN;
    return ST_FULL;
  endfunction

endpackage

// File: rtl/slotbuf_counter.sv
`timescale 1ns/1ps
module slotbuf_counter #(
  parameter int CAP    = 4,
  parameter int CW     = 3,
  parameter bit ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          give_i,
  output logic [CW-1:0] count_o,
  output logic          over_evt_o,
  output logic          ovf_o
);

  generate
    if (ENABLE) begin : g_count
      localparam logic [CW-1:0] FULL = CW'(CAP);

      logic [CW-1:0] cnt_q;
      logic          ovf_q;

      function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                                   input logic t,
                                                   input logic g);
        if (t && g) return c;
        if (t)      return (c != '0)   ? c - 1'b1 : c;
        if (g)      return (c != FULL) ? c + 1'b1 : c;
        return c;
      endfunction

      assign over_evt_o = give_i && !take_i && (cnt_q == FULL);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= FULL;
          ovf_q <= 1'b0;
        end else begin
          cnt_q <= next_count(cnt_q, take_i, give_i);
          if (over_evt_o) ovf_q <= 1'b1;
        end
      end

      assign count_o = cnt_q;
      assign ovf_o   = ovf_q;

      a_r5_take_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !give_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
      a_r5_take_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !give_i && cnt_q == '0) |=> (cnt_q == '0));
      a_r6_give_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (give_i && !take_i && cnt_q != FULL) |=> (cnt_q == $past(cnt_q) + 1'b1));
      a_r11_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && give_i) |=> $stable(cnt_q));
      a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (give_i && !take_i && cnt_q == FULL) |=> (ovf_q && cnt_q == FULL));
      a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
      a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    end else begin : g_none
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, take_i, give_i};
      assign count_o    = '0;
      assign over_evt_o = 1'b0;
      assign ovf_o      = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/slotbuf_hold_flag.sv
`timescale 1ns/1ps
module slotbuf_hold_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  a_r7_hold_until_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/slotbuf_status.sv
`timescale 1ns/1ps
module slotbuf_status
  import slotbuf_pkg::*;
(
  input  slot_mode_e   mode_i,
  input  logic         held_i,
  input  logic         has_free_i,
  output slot_status_e status_o
);

  always_comb status_o = encode_status(mode_i, held_i, has_free_i);

endmodule

// File: rtl/slotbuf_tracker.sv
`timescale 1ns/1ps
module slotbuf_tracker
  import slotbuf_pkg::*;
#(
  parameter int BUF_SIZE = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reserve_i,
  input  logic                   release_i,
  input  logic                   hold_set_i,
  input  logic                   hold_clr_i,
  output logic [1:0]             status_o,
  output logic [$clog2(((BUF_SIZE > 0) ? BUF_SIZE : 1) + 1)-1:0] free_slots_o,
  output logic                   reserved_o,
  output logic                   in_order_o,
  output logic                   overflow_o
);

  localparam int         CAP   = (BUF_SIZE > 0) ? BUF_SIZE : 1;
  localparam int         CW    = $clog2(CAP + 1);
  localparam slot_mode_e MODE  = mode_of(BUF_SIZE);
  localparam bit         HAS_Q = (BUF_SIZE > 0);

  logic          hold_set_evt;
  logic          held;
  logic [CW-1:0] count;
  logic          over_evt;
  logic          ovf;
  slot_status_e  status;

  // A reserve on a hazard resource holds it until explicitly cleared.
  assign hold_set_evt = hold_set_i || ((MODE == MODE_HAZARD) && reserve_i);

  slotbuf_counter #(
    .CAP    (CAP),
    .CW     (CW),
    .ENABLE (HAS_Q)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (reserve_i),
    .give_i     (release_i),
    .count_o    (count),
    .over_evt_o (over_evt),
    .ovf_o      (ovf)
  );

  slotbuf_hold_flag u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hold_set_evt),
    .clr_i  (hold_clr_i),
    .flag_o (held)
  );

  slotbuf_status u_status (
    .mode_i     (MODE),
    .held_i     (held),
    .has_free_i (count != '0),
    .status_o   (status)
  );

  assign status_o     = status;
  assign free_slots_o = count;
  assign reserved_o   = held;
  assign in_order_o   = (MODE == MODE_INORDER);
  assign overflow_o   = ovf;

  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status_o != 2'd3);
  a_r2_hazard_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_HAZARD) && held) |-> (status_o == 2'd2));
  a_r3_free_open: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> (status_o == 2'd0));
  a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_Q && count == '0) |-> (status_o == 2'd1));
  a_r7_hazard_reserve: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == MODE_HAZARD) && reserve_i) |=> reserved_o);
  a_r10_over_flags: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt |=> overflow_o);
  a_r6_unbuffered_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!HAS_Q) |-> (free_slots_o == '0 && !overflow_o));

endmodule

// File: tb/slotbuf_tracker_bench.sv
`timescale 1ns/1ps
module slotbuf_tracker_bench;

  localparam int N = 4;
  localparam int SZ [N] = '{4, -1, 0, 1};
  localparam int W0 = $clog2(4 + 1);
  localparam int W1 = 1;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic res = 1'b0, rel = 1'b0, hset = 1'b0, hclr = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    st [N];
  int            fs [N];
  logic          rv [N], io [N], ov [N];
  logic [W0-1:0] f0;
  logic [W1-1:0] f1, f2, f3;

  slotbuf_tracker #(.BUF_SIZE(4)) u_slotbuf_tracker (
    .clk(clk), .rst_n(rst_n), .reserve_i(res), .release_i(rel),
    .hold_set_i(hset), .hold_clr_i(hclr), .status_o(st[0]), .free_slots_o(f0),
    .reserved_o(rv[0]), .in_order_o(io[0]), .overflow_o(ov[0]));
  slotbuf_tracker #(.BUF_SIZE(-1)) u_nobuf (
    .clk(clk), .rst_n(rst_n), .reserve_i(res), .release_i(rel),
    .hold_set_i(hset), .hold_clr_i(hclr), .status_o(st[1]), .free_slots_o(f1),
    .reserved_o(rv[1]), .in_order_o(io[1]), .overflow_o(ov[1]));
  slotbuf_tracker #(.BUF_SIZE(0)) u_hazard (
    .clk(clk), .rst_n(rst_n), .reserve_i(res), .release_i(rel),
    .hold_set_i(hset), .hold_clr_i(hclr), .status_o(st[2]), .free_slots_o(f2),
    .reserved_o(rv[2]), .in_order_o(io[2]), .overflow_o(ov[2]));
  slotbuf_tracker #(.BUF_SIZE(1)) u_inorder (
    .clk(clk), .rst_n(rst_n), .reserve_i(res), .release_i(rel),
    .hold_set_i(hset), .hold_clr_i(hclr), .status_o(st[3]), .free_slots_o(f3),
    .reserved_o(rv[3]), .in_order_o(io[3]), .overflow_o(ov[3]));

  assign fs[0] = int'(f0);
  assign fs[1] = int'(f1);
  assign fs[2] = int'(f2);
  assign fs[3] = int'(f3);

  // Behavioural reference model.
  int m_slots [N];
  bit m_hold  [N];
  bit m_ovf   [N];
  int n_checks = 0, n_fail = 0;
  bit started = 0, done = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        m_slots[i] = (SZ[i] > 0) ? SZ[i] : 0;
        m_hold[i]  = 0;
        m_ovf[i]   = 0;
      end else begin
        if (hset || (SZ[i] == 0 && res)) m_hold[i] = 1;
        else if (hclr)                   m_hold[i] = 0;
        if (SZ[i] > 0 && !(res && rel)) begin
          if (res && m_slots[i] > 0) m_slots[i] = m_slots[i] - 1;
          else if (rel) begin
            if (m_slots[i] < SZ[i]) m_slots[i] = m_slots[i] + 1;
            else                    m_ovf[i] = 1;
          end
        end
      end
    end
  end

  function automatic int exp_status(input int i);
    if (SZ[i] == 0 && m_hold[i])    return 2;
    if (SZ[i] <= 0 || m_slots[i] > 0) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input string what, input int i,
                     input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s inst=%0d size=%0d actual=%0d expected=%0d t=%0t",
               req, what, i, SZ[i], act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < N; i++) begin
        chk("R1", "status code legal", i, int'(st[i] == 2'd3), 0);
        chk((exp_status(i) == 2) ? "R2" : "R3", "status", i, int'(st[i]), exp_status(i));
        // R5 R6 R11 count updates; R4 during reset
        chk(!rst_n ? "R4" : "R5/R6/R11", "free slots", i, fs[i], m_slots[i]);
        chk(!rst_n ? "R4" : "R7/R8", "hold flag", i, int'(rv[i]), int'(m_hold[i]));
        chk("R9", "in-order flag", i, int'(io[i]), int'(SZ[i] == 1));
        chk("R10", "overflow", i, int'(ov[i]), int'(m_ovf[i]));
      end
    end
  end

  task automatic step(input logic r, input logic l, input logic s, input logic c);
    @(negedge clk);
    res = r; rel = l; hset = s; hclr = c;
  endtask

  logic [31:0] lcg = 32'h1234_5678;

  initial begin
    repeat (3) step(0, 0, 0, 0);
    rst_n = 1'b1;                         // R4 reset values checked above
    step(0, 0, 0, 0);
    repeat (6) step(1, 0, 0, 0);          // R5 drain to zero and hold at zero
    step(1, 1, 0, 0);                     // R11 pair at empty
    repeat (2) step(0, 1, 0, 0);
    step(1, 1, 0, 0);                     // R11 pair mid-level
    repeat (6) step(0, 1, 0, 0);          // R6 fill, then R10 refused at full
    step(1, 1, 0, 0);                     // R11 pair at full
    step(0, 0, 0, 0);
    step(1, 0, 0, 0);                     // R7 hazard reserve sets hold
    repeat (3) step(0, 1, 0, 0);          // R7 release does not clear hold
    step(0, 0, 0, 1);                     // R8 clear
    step(0, 0, 1, 1);                     // R8 set wins
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    for (int k = 0; k < 1500; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      step(lcg[20:18] < 3'd3, lcg[24:22] < 3'd3, lcg[27:25] == 3'd0, lcg[30:28] < 3'd2);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule